// File: doc/BRIEF.md
# Single-Cycle Integer ALU

A purely combinational 32-bit arithmetic and logic unit for a simple integer datapath. A 4-bit operation code selects the result. The unit can produce bitwise logic, addition and subtraction, left and right shifts, signed and unsigned less-than tests, a pass-through of the second operand, and an upper-half merge that combines a 16-bit constant with the low half of the first operand.

The instruction decoder supplies the first operand from a register. It supplies the second operand either from a register or as an already sign-extended immediate. It also supplies the raw 16-bit immediate for the upper-half merge. The result is valid in the same cycle. Storing it is the job of the surrounding pipeline.

Top module: `alu_core`

## Requirements
- R1: Operation code 0000 gives A | B, 0001 gives A & B and 0010 gives A ^ B.
- R2: Operation code 0011 gives A + B and 0100 gives A - B, both modulo 2^32 with no carry out.
- R3: Operation code 0101 shifts A left by B[4:0]. Bits B[31:5] are ignored.
- R4: Operation code 0110 shifts A right by B[4:0] and fills with zeros. Operation code 1110 does the same shift but fills with copies of A[31]. Bits B[31:5] are ignored in both cases.
- R5: Operation code 0111 gives the bitwise complement of A.
- R6: Operation code 1010 gives 32'd1 when A < B as two's-complement values, and 32'd0 otherwise.
- R7: Operation code 1011 gives 32'd1 when A < B as unsigned values, and 32'd0 otherwise.
- R8: Operation code 1100 gives B unchanged. A and the raw immediate have no effect.
- R9: Operation code 1101 gives the raw 16-bit immediate in bits [31:16] and A[15:0] in bits [15:0].
- R10: Operation codes 1000, 1001 and 1111 give 32'd0 for every operand value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, from a register or a sign-extended immediate |
| imm_raw | input | 16 | Raw immediate, used by the upper-half merge |
| result | output | 32 | Combinational result |

## Verification
The assertions are immediate checks in a combinational process. They assume that the four inputs hold steady long enough for the result to settle, and that the result is only judged once that has happened. The bench meets this by changing all inputs together at a falling clock edge and comparing the result one nanosecond later. No input changes while a comparison is pending. Every operation code, including each reserved one, is applied with defined operand values, so no assertion ever sees X inputs.

// File: rtl/alu_core.sv
module alu_core #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [IMM_W-1:0] imm_raw,
  output logic [WIDTH-1:0] result
);
  localparam int SH_W = $clog2(WIDTH);

  localparam logic [3:0] OP_OR   = 4'b0000;
  localparam logic [3:0] OP_AND  = 4'b0001;
  localparam logic [3:0] OP_XOR  = 4'b0010;
  localparam logic [3:0] OP_ADD  = 4'b0011;
  localparam logic [3:0] OP_SUB  = 4'b0100;
  localparam logic [3:0] OP_SHL  = 4'b0101;
  localparam logic [3:0] OP_SHR  = 4'b0110;
  localparam logic [3:0] OP_NOT  = 4'b0111;
  localparam logic [3:0] OP_SLT  = 4'b1010;
  localparam logic [3:0] OP_SLTU = 4'b1011;
  localparam logic [3:0] OP_PASS = 4'b1100;
  localparam logic [3:0] OP_HI   = 4'b1101;
  localparam logic [3:0] OP_SRA  = 4'b1110;

  logic [SH_W-1:0]  shamt;
  logic [WIDTH-1:0] sum, diff, shl, shr, sra;
  logic             lt_s, lt_u;

  assign shamt = opnd_b[SH_W-1:0];
  assign sum   = opnd_a + opnd_b;
  assign diff  = opnd_a - opnd_b;
  assign shl   = opnd_a << shamt;
  assign shr   = opnd_a >> shamt;
  assign sra   = $signed(opnd_a) >>> shamt;
  assign lt_s  = $signed(opnd_a) < $signed(opnd_b);
  assign lt_u  = opnd_a < opnd_b;

  always_comb begin
    case (op_sel)
      OP_OR:   result = opnd_a | opnd_b;
      OP_AND:  result = opnd_a & opnd_b;
      OP_XOR:  result = opnd_a ^ opnd_b;
      OP_ADD:  result = sum;
      OP_SUB:  result = diff;
      OP_SHL:  result = shl;
      OP_SHR:  result = shr;
      OP_NOT:  result = ~opnd_a;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(WIDTH-1){1'b0}}, lt_u};
      OP_PASS: result = opnd_b;
      OP_HI:   result = {imm_raw, opnd_a[WIDTH-IMM_W-1:0]};
      OP_SRA:  result = sra;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [IMM_W-1:0] imm_raw,
  input logic [WIDTH-1:0] result
);
  localparam int SH_W = $clog2(WIDTH);
  logic [SH_W-1:0]  sh;
  logic [WIDTH-1:0] low_mask;
  assign sh       = opnd_b[SH_W-1:0];
  assign low_mask = (WIDTH'(1) << sh) - WIDTH'(1);

  always_comb begin
    if (op_sel == 4'b0000) a_r1_or_covers_a: assert ((opnd_a & ~result) == '0);
    if (op_sel == 4'b0001) a_r1_and_within_a: assert ((result & ~opnd_a) == '0);
    if (op_sel == 4'b0011) a_r2_add_undo: assert (result - opnd_b == opnd_a);
    if (op_sel == 4'b0100) a_r2_sub_undo: assert (result + opnd_b == opnd_a);
    if (op_sel == 4'b0101) a_r3_shl_low_clear: assert ((result & low_mask) == '0);
    if (op_sel == 4'b1110) a_r4_sra_keeps_sign: assert (result[WIDTH-1] == opnd_a[WIDTH-1]);
    if (op_sel == 4'b0111) a_r5_not_disjoint: assert ((result & opnd_a) == '0 && (result | opnd_a) == '1);
    if (op_sel == 4'b1010) a_r6_slt_bool: assert (result[WIDTH-1:1] == '0);
    if (op_sel == 4'b1011) a_r7_sltu_bool: assert (result[WIDTH-1:1] == '0);
    if (op_sel == 4'b1100) a_r8_pass_b: assert (result == opnd_b);
    if (op_sel == 4'b1101) a_r9_hi_merge: assert (result[WIDTH-1:WIDTH-IMM_W] == imm_raw
                                                  && result[WIDTH-IMM_W-1:0] == opnd_a[WIDTH-IMM_W-1:0]);
    if (op_sel == 4'b1000 || op_sel == 4'b1001 || op_sel == 4'b1111)
      a_r10_reserved_zero: assert (result == '0);
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) chk_i (
  .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_raw(imm_raw), .result(result)
);

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = 4'h0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [15:0] imm_raw = '0;
  logic [31:0] result;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alu_core dut_i (.op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_raw(imm_raw), .result(result));

  // {req, op, a, b, imm, expected}
  localparam int NV = 22;
  localparam logic [119:0] VEC [NV] = '{
    {4'd1,  4'h0, 32'hF0F0_0000, 32'h0F00_00FF, 16'h0000, 32'hFFF0_00FF}, // R1 or
    {4'd1,  4'h1, 32'hFF00_FF00, 32'h0F0F_0F0F, 16'h0000, 32'h0F00_0F00}, // R1 and
    {4'd1,  4'h2, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0000, 32'h5555_5555}, // R1 xor
    {4'd2,  4'h3, 32'hFFFF_FFFF, 32'h0000_0002, 16'h0000, 32'h0000_0001}, // R2 wrap
    {4'd2,  4'h3, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 32'h8000_0000}, // R2
    {4'd2,  4'h4, 32'h0000_0000, 32'h0000_0001, 16'h0000, 32'hFFFF_FFFF}, // R2 borrow
    {4'd2,  4'h4, 32'h0000_1000, 32'h0000_0234, 16'h0000, 32'h0000_0DCC}, // R2
    {4'd3,  4'h5, 32'h0000_0001, 32'h0000_001F, 16'h0000, 32'h8000_0000}, // R3 max
    {4'd3,  4'h5, 32'h0000_0003, 32'h0000_0024, 16'h0000, 32'h0000_0030}, // R3 upper B ignored
    {4'd4,  4'h6, 32'h8000_0000, 32'h0000_0004, 16'h0000, 32'h0800_0000}, // R4 logical
    {4'd4,  4'hE, 32'h8000_0000, 32'h0000_0004, 16'h0000, 32'hF800_0000}, // R4 arith
    {4'd4,  4'hE, 32'h4000_0000, 32'h0000_0021, 16'h0000, 32'h2000_0000}, // R4 upper B ignored
    {4'd5,  4'h7, 32'h0F0F_0000, 32'h1234_5678, 16'h0000, 32'hF0F0_FFFF}, // R5
    {4'd6,  4'hA, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 32'h0000_0001}, // R6 -1<1
    {4'd6,  4'hA, 32'h0000_0005, 32'h0000_0005, 16'h0000, 32'h0000_0000}, // R6 equal
    {4'd7,  4'hB, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 32'h0000_0000}, // R7
    {4'd7,  4'hB, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0000, 32'h0000_0001}, // R7
    {4'd8,  4'hC, 32'h1234_5678, 32'hFFFF_8000, 16'h8000, 32'hFFFF_8000}, // R8
    {4'd9,  4'hD, 32'h1234_5678, 32'h0000_0000, 16'hABCD, 32'hABCD_5678}, // R9
    {4'd10, 4'h8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 32'h0000_0000}, // R10
    {4'd10, 4'h9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 32'h0000_0000}, // R10
    {4'd10, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 32'h0000_0000}  // R10
  };

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] imm, input logic [31:0] exp, input int rq);
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; imm_raw = imm;
    #1;
    checks++;
    if (result !== exp) begin
      failures++;
      $display("FAIL R%0d op=%h a=%h b=%h imm=%h actual=%h expected=%h", rq, op, a, b, imm, result, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply(4'h0, '0, '0, '0, '0, 1); // R1 idle state after reset
    for (int i = 0; i < NV; i++)
      apply(VEC[i][115:112], VEC[i][111:80], VEC[i][79:48], VEC[i][47:32], VEC[i][31:0],
            int'(VEC[i][119:116]));
    for (int k = 0; k < 32; k++) begin
      apply(4'h5, 32'h0000_0001, 32'hFFFF_FFE0 | k, 16'h0, 32'h1 << k, 3);       // R3 sweep
      apply(4'h6, 32'h8000_0000, 32'h0000_0040 | k, 16'h0, 32'h8000_0000 >> k, 4); // R4 sweep
      apply(4'hE, 32'h8000_0000, k, 16'h0, 32'hFFFF_FFFF << (31 - k), 4);          // R4 sweep
    end
    apply(4'hC, 32'hDEAD_BEEF, 32'h0000_0000, 16'h7777, 32'h0, 8);                 // R8 A, imm ignored
    apply(4'hD, 32'hFFFF_0000, 32'hFFFF_FFFF, 16'h0000, 32'h0, 9);                 // R9 B ignored
    apply(4'hA, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 32'h1, 6);                    // R6 extremes
    apply(4'hB, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 32'h0, 7);                    // R7 extremes
    apply(4'h7, 32'h0000_0000, 32'h0, 16'h0, 32'hFFFF_FFFF, 5);                    // R5
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule